// File: doc/BRIEF.md
# Per-Channel Analog Window Watchdog

This block watches the stream of finished 10-bit converter results. Each result arrives with its channel number and a one-cycle valid strobe. An enable mask chooses which channels are checked. A checked result that sits at or beyond a programmable upper limit, or at or below a programmable lower limit, is an event. An event sets a sticky global alert flag and a sticky status bit for the channel that produced it. The interrupt line is the global flag gated by an interrupt enable. Software clears the global flag and the per-channel bits separately, using write-one-to-clear strobes.

The block has three parts. A window comparator decides whether the current result is an event and, if so, which channel it belongs to. A status bank holds one sticky bit per channel. A two-state controller holds the global flag. The controller rests in `WD_QUIET`. It takes the transition *trip* to `WD_ALERT` on any event. It takes the transition *acknowledge* back to `WD_QUIET` when the flag clear strobe is high and no event arrives in the same cycle. In every other case it stays in its current state.

Top module: `chan_window_watch`

## Requirements
- R1: After reset, `alert_flag`, `irq` and every bit of `chan_hit` are 0.
- R2: A valid result on an enabled channel whose value is greater than or equal to `thr_high` sets `alert_flag` and sets bit `res_chan` of `chan_hit`, both visible at the first rising edge after the strobe.
- R3: A valid result on an enabled channel whose value is less than or equal to `thr_low` sets `alert_flag` and bit `res_chan` of `chan_hit` in the same way.
- R4: A valid result strictly between `thr_low` and `thr_high` changes neither `alert_flag` nor `chan_hit`.
- R5: A result on a channel whose bit in `chan_en` is 0 changes neither `alert_flag` nor `chan_hit`, whatever its value. Bit n of `chan_en` enables channel n.
- R6: While `res_valid` is 0, no value on `res_data` or `res_chan` changes `alert_flag` or `chan_hit`.
- R7: An event sets only the status bit of its own channel. All other bits of `chan_hit` keep their values.
- R8: `alert_flag` and the bits of `chan_hit` stay set until cleared. A high `clr_flag` clears only `alert_flag`. A 1 in bit n of `clr_chan` clears only bit n of `chan_hit`. Each clear takes effect at the next rising edge.
- R9: When an event and a clear of the same flag or status bit fall in one cycle, the event wins and the bit stays set.
- R10: `irq` equals `alert_flag` AND `irq_en` with no register in between. Raising `irq_en` while the flag is set drives `irq` high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | One-cycle strobe marking a finished conversion |
| res_data | input | 10 | Conversion result |
| res_chan | input | 4 | Channel of the result |
| thr_high | input | 10 | Upper window limit (inclusive) |
| thr_low | input | 10 | Lower window limit (inclusive) |
| chan_en | input | 16 | Per-channel check enable |
| irq_en | input | 1 | Interrupt enable |
| clr_flag | input | 1 | Write-one-to-clear strobe for the global flag |
| clr_chan | input | 16 | Write-one-to-clear strobes for the channel status bits |
| alert_flag | output | 1 | Sticky global watchdog flag |
| chan_hit | output | 16 | Sticky per-channel event bits |
| irq | output | 1 | Interrupt line |

## Verification
Comparison is combinational and the flag and status bits are single registers. A strobe or clear that is applied in one cycle is therefore seen at the first rising edge that follows. The interrupt responds to `irq_en` inside the same cycle. The bench changes inputs on the falling edge, lets one rising edge pass, and reads the flag and status at the next falling edge. For the interrupt it reads a nanosecond after `irq_en` changes, with no clock edge in between. Tests that expect no effect read the flag and status at the same point, so a stray set would be caught before the next stimulus.

// File: rtl/awd_pkg.sv
package awd_pkg;
    localparam int unsigned DEF_DATA_W = 10;
    localparam int unsigned DEF_NUM_CH = 16;

    typedef enum logic {
        WD_QUIET = 1'b0,
        WD_ALERT = 1'b1
    } wd_state_e;
endpackage

// File: rtl/awd_window_cmp.sv
module awd_window_cmp #(
    parameter int unsigned DATA_W = awd_pkg::DEF_DATA_W,
    parameter int unsigned NUM_CH = awd_pkg::DEF_NUM_CH,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic [CH_W-1:0]   chan,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic [NUM_CH-1:0] chan_en,
    output logic              hit,
    output logic [NUM_CH-1:0] hit_vec
);
    logic at_or_above;
    logic at_or_below;
    logic checked;

    always_comb begin
        at_or_above = (data >= thr_hi);
        at_or_below = (data <= thr_lo);
        checked     = valid && chan_en[chan];
        hit         = checked && (at_or_above || at_or_below);
        hit_vec     = '0;
        if (hit) begin
            hit_vec[chan] = 1'b1;
        end
    end
endmodule

// File: rtl/awd_status_bank.sv
module awd_status_bank #(
    parameter int unsigned NUM_CH = awd_pkg::DEF_NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit_vec,
    input  logic [NUM_CH-1:0] clr_vec,
    output logic [NUM_CH-1:0] stat_q
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[i] <= 1'b0;
            end else if (hit_vec[i]) begin
                stat_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                stat_q[i] <= 1'b0;
            end
        end

        // R7, R9: an event on this channel leaves its bit set, clear or not
        p_status_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[i] |=> stat_q[i]);

        // R8: a set bit holds until its own clear strobe
        p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !clr_vec[i]) |=> stat_q[i]);
    end
endmodule

// File: rtl/awd_flag_fsm.sv
module awd_flag_fsm
    import awd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    wd_state_e state_q;
    wd_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_QUIET: if (hit)         state_d = WD_ALERT;  // trip
            WD_ALERT: if (clr && !hit) state_d = WD_QUIET;  // acknowledge
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag = (state_q == WD_ALERT);
    end

    // R2, R3, R9: every event leaves the flag set one edge later
    p_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R8: the flag only drops through the clear strobe
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R8: a clear without a competing event drops the flag
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag);
endmodule

// File: rtl/chan_window_watch.sv
module chan_window_watch #(
    parameter int unsigned DATA_W = awd_pkg::DEF_DATA_W,
    parameter int unsigned NUM_CH = awd_pkg::DEF_NUM_CH,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [DATA_W-1:0] thr_high,
    input  logic [DATA_W-1:0] thr_low,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic              irq_en,
    input  logic              clr_flag,
    input  logic [NUM_CH-1:0] clr_chan,
    output logic              alert_flag,
    output logic [NUM_CH-1:0] chan_hit,
    output logic              irq
);
    logic              hit;
    logic [NUM_CH-1:0] hit_vec;

    awd_window_cmp #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_cmp (
        .valid   (res_valid),
        .data    (res_data),
        .chan    (res_chan),
        .thr_hi  (thr_high),
        .thr_lo  (thr_low),
        .chan_en (chan_en),
        .hit     (hit),
        .hit_vec (hit_vec)
    );

    awd_status_bank #(
        .NUM_CH (NUM_CH)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_vec (hit_vec),
        .clr_vec (clr_chan),
        .stat_q  (chan_hit)
    );

    awd_flag_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (clr_flag),
        .flag  (alert_flag)
    );

    always_comb begin
        irq = alert_flag && irq_en;
    end

    // R5: a result on a masked channel leaves the status bits untouched
    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !chan_en[res_chan] && (clr_chan == '0)) |=> $stable(chan_hit));

    // R6: no strobe, no clear -> status bits unchanged
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && (clr_chan == '0)) |=> $stable(chan_hit));
endmodule

// File: tb/chan_window_watch_tb.sv
module chan_window_watch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [9:0]  res_data = '0;
    logic [3:0]  res_chan = '0;
    logic [9:0]  thr_high = 10'd600;
    logic [9:0]  thr_low = 10'd200;
    logic [15:0] chan_en = 16'hFFFF;
    logic        irq_en = 1'b0;
    logic        clr_flag = 1'b0;
    logic [15:0] clr_chan = '0;
    logic        alert_flag;
    logic [15:0] chan_hit;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    chan_window_watch u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_chan   (res_chan),
        .thr_high   (thr_high),
        .thr_low    (thr_low),
        .chan_en    (chan_en),
        .irq_en     (irq_en),
        .clr_flag   (clr_flag),
        .clr_chan   (clr_chan),
        .alert_flag (alert_flag),
        .chan_hit   (chan_hit),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic v, input logic [9:0] d, input logic [3:0] c);
        res_valid = v; res_data = d; res_chan = c;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic clear_all();
        clr_flag = 1'b1; clr_chan = 16'hFFFF;
        @(negedge clk);
        clr_flag = 1'b0; clr_chan = '0;
    endtask

    task automatic t_reset();
        check("R1 flag", {15'd0, alert_flag}, 16'd0);
        check("R1 status", chan_hit, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_inside();
        send(1'b1, 10'd400, 4'd3);
        send(1'b1, 10'd599, 4'd4);
        send(1'b1, 10'd201, 4'd6);
        check("R4 flag", {15'd0, alert_flag}, 16'd0);
        check("R4 status", chan_hit, 16'h0000);
    endtask

    task automatic t_high_irq();
        send(1'b1, 10'd600, 4'd5);
        check("R2 flag", {15'd0, alert_flag}, 16'd1);
        check("R2 R7 status", chan_hit, 16'h0020);
        check("R10 irq off", {15'd0, irq}, 16'd0);
        irq_en = 1'b1;
        #1;
        check("R10 irq same cycle", {15'd0, irq}, 16'd1);
        @(negedge clk);
        clr_flag = 1'b1;
        @(negedge clk);
        clr_flag = 1'b0;
        check("R8 flag cleared", {15'd0, alert_flag}, 16'd0);
        check("R8 status kept", chan_hit, 16'h0020);
        check("R10 irq follows flag", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_low();
        send(1'b1, 10'd200, 4'd0);
        check("R3 flag", {15'd0, alert_flag}, 16'd1);
        check("R3 R7 status", chan_hit, 16'h0021);
        clr_chan = 16'h0020;
        @(negedge clk);
        clr_chan = '0;
        check("R8 bit clear", chan_hit, 16'h0001);
        check("R8 flag kept", {15'd0, alert_flag}, 16'd1);
        send(1'b1, 10'd0, 4'd15);
        check("R3 top channel", chan_hit, 16'h8001);
        clear_all();
        check("R8 all clear", chan_hit, 16'h0000);
    endtask

    task automatic t_mask();
        chan_en = ~16'h0080;
        send(1'b1, 10'd1023, 4'd7);
        check("R5 masked flag", {15'd0, alert_flag}, 16'd0);
        check("R5 masked status", chan_hit, 16'h0000);
        send(1'b1, 10'd0, 4'd8);
        check("R5 enabled status", chan_hit, 16'h0100);
        chan_en = 16'hFFFF;
        clear_all();
    endtask

    task automatic t_novalid();
        send(1'b0, 10'd1023, 4'd2);
        send(1'b0, 10'd0, 4'd9);
        check("R6 flag", {15'd0, alert_flag}, 16'd0);
        check("R6 status", chan_hit, 16'h0000);
    endtask

    task automatic t_collide();
        send(1'b1, 10'd700, 4'd9);
        check("R9 pre", chan_hit, 16'h0200);
        clr_flag = 1'b1; clr_chan = 16'h0200;
        send(1'b1, 10'd100, 4'd9);
        clr_flag = 1'b0; clr_chan = '0;
        check("R9 flag kept", {15'd0, alert_flag}, 16'd1);
        check("R9 status kept", chan_hit, 16'h0200);
        check("R10 irq on", {15'd0, irq}, 16'd1);
        clear_all();
        check("R8 after collide", {15'd0, alert_flag}, 16'd0);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inside();
        t_high_irq();
        t_low();
        t_mask();
        t_novalid();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule